// File: doc/BRIEF.md
# Host Message Mailbox

This block carries control bytes between an external host and an on-chip processor core. The host uses a small synchronous parallel port: an active-low chip select, active-low read and write strobes, a 2-bit address and an 8-bit data bus. One shared data register carries bytes in both directions. A status register tells the host when the inbound path is still occupied and when an outbound byte is waiting. The core side has two byte streams with valid/ready handshakes: one delivers host bytes to the core and one accepts response bytes from the core.

Message framing depends on a mode input driven by the core. In boot mode the exchange is three host bytes and then one core reply byte, and the outbound stream stays closed until the three bytes have arrived. In run mode every core reply is a six-byte message. An active-low interrupt tells the host that such a message is in progress. The interrupt is never raised in boot mode. The host reads every byte with the same protocol: it polls the status register, then reads the data register. A strobe counts as one event for each clock cycle it is sampled low together with chip select.

Top module: `hmb_mailbox`

## Requirements
- R1: After reset the status register reads 0x00, `hst_irq_n` is high, `ovr_sticky` is low and `core_in_valid` is low. In run mode `core_out_ready` is high.
- R2: Address 2'b01 returns the status register. Bit 0 is inbound-busy, bit 1 is outbound-ready and bits 7..2 are zero. Addresses 2'b10 and 2'b11 read as 0x00.
- R3: A host write to address 2'b00 while inbound-busy is low stores the byte and sets inbound-busy from the next cycle. `core_in_valid` is high with that byte on `core_in_data`. Busy clears in the cycle after the core accepts the byte (`core_in_valid` and `core_in_ready` both high at a clock edge).
- R4: A host write while inbound-busy is high is ignored: `core_in_data` keeps the earlier byte. The write sets `ovr_sticky`, which stays high until reset.
- R5: When the outbound slot is empty and `core_out_ready` is high, a core byte is taken at the clock edge. Outbound-ready is set from the next cycle, a read of address 2'b00 returns that byte, and `core_out_ready` stays low while the slot is full.
- R6: A host read of address 2'b00 while outbound-ready is set clears the flag from the next cycle. Reading the status register has no side effect.
- R7: In boot mode `core_out_ready` stays low until three host writes have been accepted. Ignored writes do not count toward the three. After the host reads the single reply byte, the stream closes until three more writes are accepted.
- R8: In boot mode `hst_irq_n` stays high, even while a reply byte is pending.
- R9: In run mode `hst_irq_n` goes low in the cycle after the first byte of a message is taken. It stays low between bytes and returns high in the cycle after the host reads the sixth byte.
- R10: Any change of `boot_mode` discards frame progress: the boot write count, the run byte count and the pending interrupt.
- R11: A strobe sampled while `hst_cs_n` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_addr | input | 2 | Register select: 00 data, 01 status |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, combinational from the address |
| hst_irq_n | output | 1 | Outgoing-message interrupt, active low |
| boot_mode | input | 1 | High selects boot framing, low selects run framing |
| core_in_data | output | 8 | Host byte offered to the core |
| core_in_valid | output | 1 | Host byte is available |
| core_in_ready | input | 1 | Core accepts the host byte |
| core_out_data | input | 8 | Reply byte from the core |
| core_out_valid | input | 1 | Reply byte is offered |
| core_out_ready | output | 1 | Block can take a reply byte |
| ovr_sticky | output | 1 | A host write arrived while busy; cleared only by reset |

## Verification
Read data is combinational from the address, so a read returns the byte in the same cycle as the strobe. Every flag is a register. A busy, ready or overrun change caused by a strobe or a handshake therefore shows one clock edge after that edge, and the interrupt follows a load or a final read by exactly one edge. The bench drives all inputs on the falling edge and applies each stimulus for exactly one rising edge. It samples at the following falling edge, so every expected value is due at that point with no waiting window. The ignored-write and closed-stream cases are checked by reading the data offered to the core and the status register at that falling edge, before any further stimulus.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

  typedef enum logic [1:0] {
    SEL_MSG  = 2'b00,
    SEL_STAT = 2'b01
  } hmb_sel_e;

  localparam int unsigned BUSY_POS = 0;
  localparam int unsigned RDY_POS  = 1;

  // True when cnt is the last position of a frame of length len
  function automatic logic frame_last(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

  // Status byte: busy and ready in their bit positions, rest zero
  function automatic logic [7:0] status_byte(input logic busy, input logic rdy);
    logic [7:0] s;
    s = '0;
    s[BUSY_POS] = busy;
    s[RDY_POS]  = rdy;
    return s;
  endfunction

endpackage

// File: rtl/hmb_inbox.sv
module hmb_inbox #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [DW-1:0] wdata,
  input  logic          in_ready,
  output logic          in_valid,
  output logic [DW-1:0] in_data,
  output logic          busy,
  output logic          wr_take,
  output logic          ovr
);

  assign wr_take  = wr_evt & ~busy;
  assign in_valid = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      in_data <= '0;
      ovr     <= 1'b0;
    end else begin
      if (wr_take) begin
        in_data <= wdata;
        busy    <= 1'b1;
      end else if (busy && in_ready) begin
        busy <= 1'b0;
      end
      if (wr_evt && busy) ovr <= 1'b1;
    end
  end

endmodule

// File: rtl/hmb_outbox.sv
module hmb_outbox #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          core_valid,
  input  logic [DW-1:0] core_data,
  input  logic          rd_evt,
  output logic          core_ready,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          load_take,
  output logic          rd_take
);

  assign core_ready = ~full & load_en;
  assign load_take  = core_valid & core_ready;
  assign rd_take    = rd_evt & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (load_take) begin
      full <= 1'b1;
      data <= core_data;
    end else if (rd_take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/hmb_framer.sv
module hmb_framer
  import hmb_pkg::*;
#(
  parameter int unsigned BOOT_IN_LEN = 3,
  parameter int unsigned RUN_MSG_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boot,
  input  logic wr_take,
  input  logic load_take,
  input  logic rd_take,
  output logic load_en,
  output logic boot_open,
  output logic irq_n
);

  localparam int unsigned WC_W = $clog2(BOOT_IN_LEN + 1);
  localparam int unsigned RC_W = (RUN_MSG_LEN > 1) ? $clog2(RUN_MSG_LEN) : 1;

  logic            mode_q;
  logic [WC_W-1:0] wcnt;
  logic [RC_W-1:0] rcnt;
  logic            msg_act;
  logic            mode_chg;

  assign mode_chg  = boot != mode_q;
  assign boot_open = wcnt == WC_W'(BOOT_IN_LEN);
  assign load_en   = boot ? boot_open : 1'b1;
  assign irq_n     = ~(msg_act & ~boot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b1;
      wcnt    <= '0;
      rcnt    <= '0;
      msg_act <= 1'b0;
    end else begin
      mode_q <= boot;
      if (mode_chg) begin
        wcnt    <= '0;
        rcnt    <= '0;
        msg_act <= 1'b0;
      end else if (boot) begin
        if (rd_take)                    wcnt <= '0;
        else if (wr_take && !boot_open) wcnt <= wcnt + 1'b1;
      end else begin
        if (load_take) msg_act <= 1'b1;
        if (rd_take) begin
          if (frame_last(int'(rcnt), RUN_MSG_LEN)) begin
            rcnt    <= '0;
            msg_act <= 1'b0;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/hmb_mailbox.sv
module hmb_mailbox
  import hmb_pkg::*;
#(
  parameter int unsigned BOOT_IN_LEN = 3,
  parameter int unsigned RUN_MSG_LEN = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hst_cs_n,
  input  logic       hst_rd_n,
  input  logic       hst_wr_n,
  input  logic [1:0] hst_addr,
  input  logic [7:0] hst_wdata,
  output logic [7:0] hst_rdata,
  output logic       hst_irq_n,
  input  logic       boot_mode,
  output logic [7:0] core_in_data,
  output logic       core_in_valid,
  input  logic       core_in_ready,
  input  logic [7:0] core_out_data,
  input  logic       core_out_valid,
  output logic       core_out_ready,
  output logic       ovr_sticky
);

  logic       wr_evt, rd_evt;
  logic       in_busy, wr_take;
  logic       out_full, load_take, rd_take, load_en, boot_open;
  logic [7:0] out_data;

  assign wr_evt = ~hst_cs_n & ~hst_wr_n & (hst_addr == SEL_MSG);
  assign rd_evt = ~hst_cs_n & ~hst_rd_n & (hst_addr == SEL_MSG);

  hmb_inbox #(.DW(8)) u_inbox (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_evt   (wr_evt),
    .wdata    (hst_wdata),
    .in_ready (core_in_ready),
    .in_valid (core_in_valid),
    .in_data  (core_in_data),
    .busy     (in_busy),
    .wr_take  (wr_take),
    .ovr      (ovr_sticky)
  );

  hmb_outbox #(.DW(8)) u_outbox (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .core_valid (core_out_valid),
    .core_data  (core_out_data),
    .rd_evt     (rd_evt),
    .core_ready (core_out_ready),
    .full       (out_full),
    .data       (out_data),
    .load_take  (load_take),
    .rd_take    (rd_take)
  );

  hmb_framer #(.BOOT_IN_LEN(BOOT_IN_LEN), .RUN_MSG_LEN(RUN_MSG_LEN)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot      (boot_mode),
    .wr_take   (wr_take),
    .load_take (load_take),
    .rd_take   (rd_take),
    .load_en   (load_en),
    .boot_open (boot_open),
    .irq_n     (hst_irq_n)
  );

  always_comb begin
    case (hst_addr)
      SEL_MSG:  hst_rdata = out_data;
      SEL_STAT: hst_rdata = status_byte(in_busy, out_full);
      default:  hst_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/hmb_mailbox_chk.sv
module hmb_mailbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       boot_mode,
  input logic [1:0] hst_addr,
  input logic [7:0] hst_rdata,
  input logic       hst_irq_n,
  input logic       core_in_valid,
  input logic       core_in_ready,
  input logic [7:0] core_in_data,
  input logic       core_out_ready,
  input logic       ovr_sticky,
  input logic       wr_evt,
  input logic       rd_evt,
  input logic       in_busy,
  input logic       out_full,
  input logic       boot_open
);

  assert_status_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hst_addr == 2'b01 |-> hst_rdata[7:2] == 6'd0);

  assert_write_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && !in_busy |=> in_busy);

  assert_hold_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_in_valid && !core_in_ready |=> core_in_valid && $stable(core_in_data));

  assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_sticky |=> ovr_sticky);

  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_full |-> !core_out_ready);

  assert_read_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt && out_full |=> !out_full);

  assert_boot_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_mode && !boot_open |-> !core_out_ready);

  assert_boot_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_mode |-> hst_irq_n);

endmodule

bind hmb_mailbox hmb_mailbox_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .boot_mode      (boot_mode),
  .hst_addr       (hst_addr),
  .hst_rdata      (hst_rdata),
  .hst_irq_n      (hst_irq_n),
  .core_in_valid  (core_in_valid),
  .core_in_ready  (core_in_ready),
  .core_in_data   (core_in_data),
  .core_out_ready (core_out_ready),
  .ovr_sticky     (ovr_sticky),
  .wr_evt         (wr_evt),
  .rd_evt         (rd_evt),
  .in_busy        (in_busy),
  .out_full       (out_full),
  .boot_open      (boot_open)
);

// File: tb/hmb_mailbox_tb.sv
module hmb_mailbox_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_cs_n = 1'b1, hst_rd_n = 1'b1, hst_wr_n = 1'b1;
  logic [1:0] hst_addr = 2'b00;
  logic [7:0] hst_wdata = 8'h00;
  logic [7:0] hst_rdata;
  logic       hst_irq_n;
  logic       boot_mode = 1'b0;
  logic [7:0] core_in_data;
  logic       core_in_valid;
  logic       core_in_ready = 1'b0;
  logic [7:0] core_out_data = 8'h00;
  logic       core_out_valid = 1'b0;
  logic       core_out_ready;
  logic       ovr_sticky;

  int vecs = 0;
  int miss = 0;

  always #10 clk = ~clk;

  hmb_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .hst_cs_n(hst_cs_n), .hst_rd_n(hst_rd_n),
    .hst_wr_n(hst_wr_n), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .hst_irq_n(hst_irq_n), .boot_mode(boot_mode),
    .core_in_data(core_in_data), .core_in_valid(core_in_valid),
    .core_in_ready(core_in_ready), .core_out_data(core_out_data),
    .core_out_valid(core_out_valid), .core_out_ready(core_out_ready),
    .ovr_sticky(ovr_sticky)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic boot);
    @(negedge clk);
    rst_n = 1'b0; boot_mode = boot;
    hst_cs_n = 1'b1; hst_rd_n = 1'b1; hst_wr_n = 1'b1; hst_addr = 2'b00;
    core_in_ready = 1'b0; core_out_valid = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic host_write(input logic [7:0] d, input logic cs_n = 1'b0);
    hst_cs_n = cs_n; hst_wr_n = 1'b0; hst_addr = 2'b00; hst_wdata = d;
    tick();
    hst_cs_n = 1'b1; hst_wr_n = 1'b1;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    hst_cs_n = 1'b0; hst_rd_n = 1'b0; hst_addr = a;
    #1 d = hst_rdata;
    tick();
    hst_cs_n = 1'b1; hst_rd_n = 1'b1;
  endtask

  function automatic logic [7:0] peek_status();
    return hst_rdata;
  endfunction

  task automatic get_status(output logic [7:0] s);
    hst_addr = 2'b01;
    #1 s = peek_status();
  endtask

  task automatic core_push(input logic [7:0] d);
    core_out_valid = 1'b1; core_out_data = d;
    tick();
    core_out_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    do_reset(1'b0);
    get_status(s);
    check("R1 status after reset", s, 8'h00);
    check("R1 irq after reset", hst_irq_n, 1);
    check("R1 overrun after reset", ovr_sticky, 0);
    check("R1 in_valid after reset", core_in_valid, 0);
    check("R1 out_ready after reset", core_out_ready, 1);
  endtask

  task automatic t_inbound();
    logic [7:0] s;
    do_reset(1'b0);
    host_write(8'h5A);
    get_status(s);
    check("R3 busy after write", s, 8'h01);
    check("R3 in_valid", core_in_valid, 1);
    check("R3 in_data", core_in_data, 8'h5A);
    host_write(8'hC3);
    check("R4 data kept on ignored write", core_in_data, 8'h5A);
    check("R4 overrun set", ovr_sticky, 1);
    core_in_ready = 1'b1;
    tick();
    core_in_ready = 1'b0;
    get_status(s);
    check("R3 busy clears after accept", s, 8'h00);
    check("R4 overrun stays", ovr_sticky, 1);
    host_write(8'h11, 1'b1);
    get_status(s);
    check("R11 write without select ignored", s, 8'h00);
    check("R11 in_valid stays low", core_in_valid, 0);
  endtask

  task automatic t_run_msg();
    logic [7:0] s, d;
    do_reset(1'b0);
    for (int i = 0; i < 6; i++) begin
      check("R5 ready before load", core_out_ready, 1);
      core_push(8'h10 + 8'(i));
      get_status(s);
      check("R5 outbound ready set", s, 8'h02);
      check("R5 stream blocked while full", core_out_ready, 0);
      check("R9 irq low during message", hst_irq_n, 0);
      if (i == 0) begin
        tick();
        get_status(s);
        check("R6 status read no side effect", s, 8'h02);
        host_read(2'b10, d);
        check("R2 unused address reads zero", d, 8'h00);
        hst_cs_n = 1'b1; hst_rd_n = 1'b0; hst_addr = 2'b00;
        tick();
        hst_rd_n = 1'b1;
        get_status(s);
        check("R11 read without select ignored", s, 8'h02);
      end
      host_read(2'b00, d);
      check("R5 byte returned", d, 8'h10 + 8'(i));
      get_status(s);
      check("R6 ready cleared by read", s, 8'h00);
      check("R9 irq after read", hst_irq_n, (i == 5) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_boot();
    logic [7:0] s, d;
    do_reset(1'b1);
    check("R7 stream closed at boot start", core_out_ready, 0);
    host_write(8'h01);
    host_write(8'h02);
    host_write(8'h03);
    check("R7 closed after ignored writes", core_out_ready, 0);
    core_in_ready = 1'b1;
    tick();
    host_write(8'h04);
    tick();
    core_push(8'h77);
    get_status(s);
    check("R7 no load before third write", s, 8'h00);
    host_write(8'h05);
    check("R7 open after three writes", core_out_ready, 1);
    tick();
    core_push(8'hA5);
    get_status(s);
    check("R5 boot reply pending", s, 8'h02);
    check("R8 no irq in boot", hst_irq_n, 1);
    host_read(2'b00, d);
    check("R5 boot reply byte", d, 8'hA5);
    check("R7 closed after reply read", core_out_ready, 0);
    check("R8 irq still high", hst_irq_n, 1);
    core_in_ready = 1'b0;
  endtask

  task automatic t_mode_switch();
    logic [7:0] d;
    do_reset(1'b0);
    core_push(8'h21);
    host_read(2'b00, d);
    check("R9 irq low mid message", hst_irq_n, 0);
    boot_mode = 1'b1;
    tick();
    check("R10 irq high after switch to boot", hst_irq_n, 1);
    boot_mode = 1'b0;
    tick();
    check("R10 pending message dropped", hst_irq_n, 1);
    for (int i = 0; i < 6; i++) begin
      core_push(8'h30 + 8'(i));
      host_read(2'b00, d);
      check("R10 count restarts", hst_irq_n, (i == 5) ? 1'b1 : 1'b0);
    end
  endtask

  initial begin
    #4000000;
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    t_reset();
    t_inbound();
    t_run_msg();
    t_boot();
    t_mode_switch();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule